// File: doc/BRIEF.md
# Processor Bus Machine-Cycle Sequencer

This block produces the external bus timing of an 8-bit processor. The core asks for one bus operation at a time by presenting an operation kind, an address and, for writes, a data byte, and by pulsing a start strobe. The sequencer then walks the operation through whole clock periods (T states T1, T2, optional wait states TW, then T3 and onward). It drives the active-low memory request, I/O request, read, write, fetch marker and refresh strobes together with the address bus, and it returns a one-clock done pulse with the captured read byte.

Slow devices stretch an operation by holding the active-low wait input low. That input is sampled on the falling clock edge during T2 and during every wait state. Each active sample adds one more wait state. An opcode fetch ends with a refresh tail. During that tail the low seven address bits carry a refresh row from a free-running counter, and the upper address bits are zero. I/O operations always take one automatic wait state after T2. Opcode fetches last `FETCH_T` states (4 to 6) and data operations last `DATA_T` states (3 to 5), both counted before any wait states are added.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset the sequencer is idle. All six strobes are high, the address bus is 0, done is low, the read byte is 0 and the refresh counter is 0.
- R2: An opcode fetch (op code 2'b00) drives memory request, read and fetch marker low with the request address during T1, T2 and every wait state. It lasts FETCH_T states plus the wait states.
- R3: In T3 and T4 of a fetch, refresh and memory request are low and the address bus is {zeros, refresh counter}. In T5 and T6 of a fetch all strobes are high.
- R4: The refresh counter advances by one after each completed fetch and wraps from 127 to 0.
- R5: The wait input is sampled on the falling edge in T2 and in each wait state. Every low sample inserts one further wait state.
- R6: An I/O operation (op code 2'b11, direction io_wr_i = 1 for write) inserts one automatic wait state after T2, and then the wait states requested by the input. I/O request is low in T2, all wait states and T3. Read is low in the same states for an input. Write is low in T2 and the wait states for an output. Memory request stays high.
- R7: A memory read (op code 2'b01) holds memory request and read low from T1 through T3. It lasts DATA_T states plus the wait states.
- R8: A memory write (op code 2'b10) holds memory request low from T1 through T3 and write low only in T2 and the wait states. The data output holds the request's write byte while write is low. Read and write are never low together.
- R9: For a fetch, a memory read or an I/O input, the read byte is taken from the data input at the end of the last T2/wait state and is presented when done is high.
- R10: Done is high for exactly one clock, in the final T state of each operation.
- R11: A start seen while idle or in the final state begins T1 on the next clock, so back-to-back operations have no gap. With no start, the sequencer goes idle with all strobes high.
- R12: A start seen in any other state is ignored. The running operation keeps its timing, address and kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request strobe from the core |
| op_i | input | 2 | Operation kind: 00 fetch, 01 memory read, 10 memory write, 11 I/O |
| io_wr_i | input | 1 | Direction of an I/O operation, 1 = write |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Byte to be written |
| rd_data_i | input | DATA_W | Data bus input from memory or I/O |
| wait_n_i | input | 1 | Wait request, active low |
| mreq_n_o | output | 1 | Memory request, active low |
| iorq_n_o | output | 1 | I/O request, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| m1_n_o | output | 1 | Opcode fetch marker, active low |
| rfsh_n_o | output | 1 | Refresh strobe, active low |
| addr_o | output | ADDR_W | Address bus |
| wr_data_o | output | DATA_W | Data bus output for writes |
| rdata_o | output | DATA_W | Captured read byte |
| done_o | output | 1 | One-clock end-of-operation pulse |

## Verification
The embedded properties check the following on every clock:
- memory and I/O requests are never low together, and read and write are never low together;
- the fetch marker always coincides with a memory read;
- the upper address bits are zero during refresh;
- done never lasts two clocks;
- the refresh counter only steps by one;
- an active wait sample keeps the sequencer in a wait state, and I/O always enters the automatic wait state;
- a start seen mid-operation never restarts T1.

Only the bench scenarios can show the exact cycle of each strobe edge, the operation lengths under each wait count, the sample point of the read byte, the refresh row sequence across the wrap, and zero-gap chaining. The bench covers every operation kind and direction against zero to three requested wait states.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [1:0] {
    OP_FETCH = 2'b00,
    OP_MRD   = 2'b01,
    OP_MWR   = 2'b10,
    OP_IO    = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_TX   = 3'd4
  } phase_e;

  typedef struct packed {
    logic mreq_n;
    logic iorq_n;
    logic rd_n;
    logic wr_n;
    logic m1_n;
    logic rfsh_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{default: 1'b1};

endpackage

// File: rtl/bseq_wait_sampler.sv
module bseq_wait_sampler (
  input  logic clk,
  input  logic rst,
  input  logic wait_n_i,
  output logic wait_hit_o
);
  // Falling-edge capture: the result is stable for the next rising edge.
  always_ff @(negedge clk) begin
    if (rst) wait_hit_o <= 1'b0;
    else     wait_hit_o <= ~wait_n_i;
  end
endmodule

// File: rtl/bseq_phase_ctrl.sv
module bseq_phase_ctrl
  import bus_seq_pkg::*;
#(
  parameter int FETCH_T = 4,
  parameter int DATA_T  = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [1:0]  op_i,
  input  logic        io_wr_i,
  input  logic        wait_hit_i,
  output phase_e      phase_q,
  output logic [2:0]  tnum_q,
  output op_e         op_q,
  output phase_e      nxt_phase_o,
  output logic [2:0]  nxt_tnum_o,
  output op_e         nxt_op_o,
  output logic        nxt_iow_o,
  output logic        nxt_final_o,
  output logic        accept_o,
  output logic        capture_o,
  output logic        fetch_end_o
);
  localparam logic [2:0] LAST_F  = 3'(FETCH_T);
  localparam logic [2:0] LAST_D  = 3'(DATA_T);
  localparam logic [2:0] FIRST_X = 3'd3;

  logic iow_q;
  logic in_final;

  always_comb begin
    in_final = (phase_q == PH_TX) &&
               (tnum_q == ((op_q == OP_FETCH) ? LAST_F : LAST_D));
  end

  always_comb begin
    nxt_phase_o = phase_q;
    nxt_tnum_o  = tnum_q;
    nxt_op_o    = op_q;
    nxt_iow_o   = iow_q;
    accept_o    = start_i && ((phase_q == PH_IDLE) || in_final);
    case (phase_q)
      PH_IDLE: nxt_phase_o = PH_IDLE;
      PH_T1:   nxt_phase_o = PH_T2;
      PH_T2: begin
        if ((op_q == OP_IO) || wait_hit_i) begin
          nxt_phase_o = PH_TW;
        end else begin
          nxt_phase_o = PH_TX;
          nxt_tnum_o  = FIRST_X;
        end
      end
      PH_TW: begin
        if (!wait_hit_i) begin
          nxt_phase_o = PH_TX;
          nxt_tnum_o  = FIRST_X;
        end
      end
      PH_TX: begin
        if (in_final) nxt_phase_o = PH_IDLE;
        else          nxt_tnum_o  = tnum_q + 3'd1;
      end
      default: nxt_phase_o = PH_IDLE;
    endcase
    if (accept_o) begin
      nxt_phase_o = PH_T1;
      nxt_tnum_o  = '0;
      nxt_op_o    = op_e'(op_i);
      nxt_iow_o   = io_wr_i;
    end
  end

  always_comb begin
    nxt_final_o = (nxt_phase_o == PH_TX) &&
                  (nxt_tnum_o == ((nxt_op_o == OP_FETCH) ? LAST_F : LAST_D));
    capture_o   = ((phase_q == PH_T2) || (phase_q == PH_TW)) && (nxt_phase_o == PH_TX);
    fetch_end_o = in_final && (op_q == OP_FETCH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      tnum_q  <= '0;
      op_q    <= OP_FETCH;
      iow_q   <= 1'b0;
    end else begin
      phase_q <= nxt_phase_o;
      tnum_q  <= nxt_tnum_o;
      op_q    <= nxt_op_o;
      iow_q   <= nxt_iow_o;
    end
  end

  AST_WAIT_EXTENDS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_TW && wait_hit_i) |=> (phase_q == PH_TW)); // R5
  AST_IO_AUTO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_T2 && op_q == OP_IO) |=> (phase_q == PH_TW)); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start_i && (phase_q == PH_T1 || phase_q == PH_T2 || phase_q == PH_TW))
      |=> (phase_q != PH_T1)); // R12
  AST_TNUM_RANGE: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_TX) |-> (tnum_q >= FIRST_X &&
      tnum_q <= ((op_q == OP_FETCH) ? LAST_F : LAST_D))); // R2
endmodule

// File: rtl/bseq_strobe_dec.sv
module bseq_strobe_dec
  import bus_seq_pkg::*;
(
  input  phase_e     phase_i,
  input  logic [2:0] tnum_i,
  input  op_e        op_i,
  input  logic       iow_i,
  output strobe_t    strb_o
);
  logic early, mid, t3, tail34;

  always_comb begin
    early  = (phase_i == PH_T1) || (phase_i == PH_T2) || (phase_i == PH_TW);
    mid    = (phase_i == PH_T2) || (phase_i == PH_TW);
    t3     = (phase_i == PH_TX) && (tnum_i == 3'd3);
    tail34 = (phase_i == PH_TX) && (tnum_i <= 3'd4);
    strb_o = STROBE_IDLE;
    case (op_i)
      OP_FETCH: begin
        if (early) begin
          strb_o.mreq_n = 1'b0;
          strb_o.rd_n   = 1'b0;
          strb_o.m1_n   = 1'b0;
        end else if (tail34) begin
          strb_o.mreq_n = 1'b0;
          strb_o.rfsh_n = 1'b0;
        end
      end
      OP_MRD: begin
        if (early || t3) begin
          strb_o.mreq_n = 1'b0;
          strb_o.rd_n   = 1'b0;
        end
      end
      OP_MWR: begin
        if (early || t3) strb_o.mreq_n = 1'b0;
        if (mid)         strb_o.wr_n   = 1'b0;
      end
      default: begin
        if (mid || t3) begin
          strb_o.iorq_n = 1'b0;
          if (!iow_i) strb_o.rd_n = 1'b0;
        end
        if (mid && iow_i) strb_o.wr_n = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bseq_rfsh_ctr.sv
module bseq_rfsh_ctr #(
  parameter int RFSH_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_i,
  output logic [RFSH_W-1:0] row_o
);
  always_ff @(posedge clk) begin
    if (rst)        row_o <= '0;
    else if (inc_i) row_o <= row_o + 1'b1;
  end

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(row_o) |-> (row_o == RFSH_W'($past(row_o) + 1'b1))); // R4
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int RFSH_W  = 7,
  parameter int FETCH_T = 4,
  parameter int DATA_T  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              wait_n_i,
  output logic              mreq_n_o,
  output logic              iorq_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              m1_n_o,
  output logic              rfsh_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  localparam int HI_W = ADDR_W - RFSH_W;

  logic              wait_hit;
  phase_e            phase_q, nxt_phase;
  logic [2:0]        tnum_q, nxt_tnum;
  op_e               op_q, nxt_op;
  logic              nxt_iow, nxt_final, accept, capture, fetch_end;
  logic [RFSH_W-1:0] row;
  strobe_t           nxt_strb, strb_q;
  logic [ADDR_W-1:0] op_addr_q, nxt_addr, addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              done_q;
  logic              iow_cur_q;

  bseq_wait_sampler u_wait (
    .clk        (clk),
    .rst        (rst),
    .wait_n_i   (wait_n_i),
    .wait_hit_o (wait_hit)
  );

  bseq_phase_ctrl #(
    .FETCH_T (FETCH_T),
    .DATA_T  (DATA_T)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .op_i        (op_i),
    .io_wr_i     (io_wr_i),
    .wait_hit_i  (wait_hit),
    .phase_q     (phase_q),
    .tnum_q      (tnum_q),
    .op_q        (op_q),
    .nxt_phase_o (nxt_phase),
    .nxt_tnum_o  (nxt_tnum),
    .nxt_op_o    (nxt_op),
    .nxt_iow_o   (nxt_iow),
    .nxt_final_o (nxt_final),
    .accept_o    (accept),
    .capture_o   (capture),
    .fetch_end_o (fetch_end)
  );

  bseq_strobe_dec u_dec (
    .phase_i (nxt_phase),
    .tnum_i  (nxt_tnum),
    .op_i    (nxt_op),
    .iow_i   (nxt_iow),
    .strb_o  (nxt_strb)
  );

  bseq_rfsh_ctr #(
    .RFSH_W (RFSH_W)
  ) u_rfsh (
    .clk   (clk),
    .rst   (rst),
    .inc_i (fetch_end),
    .row_o (row)
  );

  always_comb begin
    if (nxt_phase == PH_IDLE)
      nxt_addr = addr_q;
    else if (nxt_op == OP_FETCH && nxt_phase == PH_TX)
      nxt_addr = {{HI_W{1'b0}}, row};
    else if (accept)
      nxt_addr = addr_i;
    else
      nxt_addr = op_addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q    <= STROBE_IDLE;
      addr_q    <= '0;
      op_addr_q <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      done_q    <= 1'b0;
      iow_cur_q <= 1'b0;
    end else begin
      strb_q    <= nxt_strb;
      addr_q    <= nxt_addr;
      done_q    <= nxt_final;
      iow_cur_q <= nxt_iow;
      if (accept) begin
        op_addr_q <= addr_i;
        wdata_q   <= wdata_i;
      end
      if (capture && (op_q != OP_MWR) && !(op_q == OP_IO && iow_cur_q))
        rdata_q <= rd_data_i;
    end
  end

  assign mreq_n_o  = strb_q.mreq_n;
  assign iorq_n_o  = strb_q.iorq_n;
  assign rd_n_o    = strb_q.rd_n;
  assign wr_n_o    = strb_q.wr_n;
  assign m1_n_o    = strb_q.m1_n;
  assign rfsh_n_o  = strb_q.rfsh_n;
  assign addr_o    = addr_q;
  assign wr_data_o = wdata_q;
  assign rdata_o   = rdata_q;
  assign done_o    = done_q;

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!mreq_n_o && !iorq_n_o)); // R6
  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n_o && !wr_n_o)); // R8
  AST_FETCH_IS_READ: assert property (@(posedge clk) disable iff (rst)
    !m1_n_o |-> (!rd_n_o && !mreq_n_o)); // R2
  AST_RFSH_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!rfsh_n_o && !mreq_n_o) |-> (addr_o[ADDR_W-1:RFSH_W] == '0)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (!wr_n_o && $past(!wr_n_o)) |-> $stable(wr_data_o)); // R8
endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FT = 5;
  localparam int DT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        iow = 1'b0;
  logic [15:0] addr_in = '0;
  logic [7:0]  wdata_in = '0;
  logic [7:0]  din = '0;
  logic        wait_n = 1'b1;
  logic        mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, done;
  logic [15:0] abus;
  logic [7:0]  wr_data, rd_data;

  int checks = 0;
  int errors = 0;
  int rexp   = 0;

  bus_cycle_seq #(
    .ADDR_W (16), .DATA_W (8), .RFSH_W (7), .FETCH_T (FT), .DATA_T (DT)
  ) dut_i (
    .clk (clk), .rst (rst), .start_i (start), .op_i (op), .io_wr_i (iow),
    .addr_i (addr_in), .wdata_i (wdata_in), .rd_data_i (din), .wait_n_i (wait_n),
    .mreq_n_o (mreq_n), .iorq_n_o (iorq_n), .rd_n_o (rd_n), .wr_n_o (wr_n),
    .m1_n_o (m1_n), .rfsh_n_o (rfsh_n), .addr_o (abus), .wr_data_o (wr_data),
    .rdata_o (rd_data), .done_o (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ph: 1 T1, 2 T2, 3 TW, 4 T3 and later (tn = state number)
  function automatic logic [5:0] exp_strobes(int o, bit w, int ph, int tn);
    logic mq = 1, iq = 1, rd = 1, wr = 1, m1 = 1, rf = 1;
    case (o)
      0: if (ph <= 3) begin mq = 0; rd = 0; m1 = 0; end
         else if (tn <= 4) begin mq = 0; rf = 0; end
      1: if (ph <= 3 || tn == 3) begin mq = 0; rd = 0; end
      2: begin
           if (ph <= 3 || tn == 3) mq = 0;
           if (ph == 2 || ph == 3) wr = 0;
         end
      default: begin
           if (ph >= 2 && (ph <= 3 || tn == 3)) begin iq = 0; if (!w) rd = 0; end
           if (w && (ph == 2 || ph == 3)) wr = 0;
         end
    endcase
    return {mq, iq, rd, wr, m1, rf};
  endfunction

  task automatic run_op(int o, bit w, logic [15:0] a, logic [7:0] wd, int nw,
                        bit pre, bit chain, bit poke,
                        int no, bit nwr, logic [15:0] na, logic [7:0] nwd);
    int autow = (o == 3) ? 1 : 0;
    int len   = (o == 0) ? FT : DT;
    int total = len + autow + nw;
    logic [7:0] good = a[7:0] ^ 8'h5A;
    bit reads = (o == 0) || (o == 1) || (o == 3 && !w);
    if (!pre) begin
      op = 2'(o); iow = w; addr_in = a; wdata_in = wd; start = 1'b1;
    end
    for (int i = 0; i < total; i++) begin
      int ph;
      int tn;
      string tag;
      logic [5:0] es;
      @(posedge clk); #1;
      if (i == 0) start = 1'b0;
      if (poke && i == 1) begin start = 1'b1; op = 2'd2; addr_in = 16'hDEAD; end
      if (poke && i == 2) start = 1'b0;
      if (o == 3) wait_n = !(i >= 2 && i < 2 + nw);
      else        wait_n = !(i >= 1 && i < 1 + nw);
      din = (i >= 1 && i < 2 + autow + nw) ? good : ~good;
      tn = 0;
      if (i == 0) ph = 1;
      else if (i == 1) ph = 2;
      else if (i < 2 + autow + nw) ph = 3;
      else begin ph = 4; tn = i - (autow + nw) + 1; end
      #(CLK_PERIOD/4);
      if (poke) tag = "R12";
      else if (pre && i == 0) tag = "R11";
      else if (ph == 3 && !(o == 3 && i == 2)) tag = "R5";
      else if (o == 0) tag = (ph == 4) ? "R3" : "R2";
      else if (o == 1) tag = "R7";
      else if (o == 2) tag = "R8";
      else tag = "R6";
      es = exp_strobes(o, w, ph, tn);
      chk(tag, "strobes {mreq,iorq,rd,wr,m1,rfsh}",
          int'({mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n}), int'(es));
      if (o == 0 && ph == 4) chk("R4", "refresh address", int'(abus), rexp);
      else chk(tag, "address", int'(abus), int'(a));
      chk("R10", "done", int'(done), (i == total - 1) ? 1 : 0);
      if (!es[2]) chk("R8", "write data", int'(wr_data), int'(wd));
      if (reads && i == total - 1) chk("R9", "read byte", int'(rd_data), int'(good));
      if (chain && i == total - 1) begin
        op = 2'(no); iow = nwr; addr_in = na; wdata_in = nwd; start = 1'b1;
      end
    end
    if (o == 0) rexp = (rexp + 1) % 128;
    wait_n = 1'b1;
    if (!chain) begin
      @(posedge clk); #1; #(CLK_PERIOD/4);
      chk("R11", "idle strobes", int'({mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n}), 'h3F);
      chk("R11", "idle done", int'(done), 0);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #(CLK_PERIOD/4);
    chk("R1", "reset strobes", int'({mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n}), 'h3F);
    chk("R1", "reset address", int'(abus), 0);
    chk("R1", "reset done", int'(done), 0);
    chk("R1", "reset read byte", int'(rd_data), 0);
    // first fetch must show refresh row 0
    run_op(0, 0, 16'h0040, 8'h00, 0, 0, 0, 0, 0, 0, 16'h0, 8'h0);
    // sweep: every kind, both I/O directions, 0..3 requested waits
    for (int o = 0; o < 4; o++) begin
      for (int w = 0; w < ((o == 3) ? 2 : 1); w++) begin
        for (int nw = 0; nw < 4; nw++) begin
          run_op(o, w[0], 16'(16'h0100 * (o + 1) + nw * 16 + w), 8'(8'hA0 + o * 8 + nw),
                 nw, 0, 0, 0, 0, 0, 16'h0, 8'h0);
        end
      end
    end
    // back-to-back: read chained into write
    run_op(1, 0, 16'h2222, 8'h00, 0, 0, 1, 0, 2, 0, 16'h3333, 8'h77);
    run_op(2, 0, 16'h3333, 8'h77, 1, 1, 0, 0, 0, 0, 16'h0, 8'h0);
    // start while busy must be ignored
    run_op(1, 0, 16'h4444, 8'h00, 2, 0, 0, 1, 0, 0, 16'h0, 8'h0);
    run_op(3, 1, 16'h0055, 8'h3C, 1, 0, 0, 1, 0, 0, 16'h0, 8'h0);
    // refresh row wrap over a long chain of fetches
    for (int k = 0; k < 130; k++) begin
      run_op(0, 0, 16'(16'h8000 + k), 8'h00, k % 2, (k > 0), (k < 129), 0,
             0, 0, 16'(16'h8000 + k + 1), 8'h00);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule